// File: doc/BRIEF.md
# Serial Port Register Bank with Ranked Interrupts

This block is the processor-facing side of an asynchronous serial port. A simple single-cycle bus (select, write flag, 3-bit word index, byte data) reaches a small set of byte registers. One bit in the line-control register swaps what the two lowest indices reach. With that bit clear, index 0 is the data port toward the transmit and receive FIFOs, and index 1 holds the interrupt enables. With that bit set, both indices reach the two bytes of the baud divisor instead. The block drives push and pop strobes toward the FIFOs. It also exports the framing fields and the 16-bit divisor to the serial engines, which sit outside this block.

Five interrupt causes feed a fixed-rank encoder:

- line errors (overrun, parity, framing, break)
- receive level reached
- receive timeout
- transmit FIFO empty
- a change on the CTS or DSR modem inputs

The encoder drives one interrupt line and a 4-bit cause code. Software reads the code and then services the cause: it reads the line-status or modem-status register, drains the receive FIFO, or refills the transmit FIFO. Loopback operation is not provided.

Top module: `sio_regbank`

## Requirements
- R1: After synchronous reset, the following are all zero: divisor, interrupt enables, line-control fields and `irq`. `irq_id` reads 4'b0001.
- R2: With the access bit clear, a write to index 0 gives a one-cycle `tx_push` with `tx_data` equal to the written byte, in the cycle after the bus cycle. A read of index 0 returns `rx_data` on `rd_data` and gives a one-cycle `rx_pop`, both in the cycle after the bus cycle.
- R3: With the access bit set, index 0 holds the divisor low byte and index 1 holds the divisor high byte. Both read back, `divisor` = {high, low}, and accesses to index 0 give neither `tx_push` nor `rx_pop`.
- R4: With the access bit clear, index 1 is the enable register. Bit 0 enables receive data (level and timeout), bit 1 transmit empty, bit 2 line errors and bit 3 modem change. Bits 7:4 read zero.
- R5: Index 3 is the line-control register:
  - bits 1:0 drive `char_len` (0 = 5 bits … 3 = 8 bits)
  - bit 2 drives `stop2`
  - bit 3 drives `par_en`
  - bit 4 drives `par_odd`
  - bit 7 is the divisor access bit
  - bits 6:5 read zero.
- R6: A pulse on an error input latches a status bit, read at index 5 as follows: bit 0 `rx_avail`, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 5 `tx_empty`. The read returns the latched bits and clears them. While enabled and pending, the line cause reports code 4'b0110.
- R7: While enabled, a high `rx_lvl_hit` reports code 4'b0100. A high `rx_tmo` without `rx_lvl_hit` reports 4'b1100.
- R8: The transmit-empty cause becomes pending in two cases: on a rising edge of `tx_empty`, or when its enable is written from 0 to 1 while `tx_empty` is high. It reports 4'b0010. It clears on a transmit-data write, or on a read of index 2 while `irq_id` shows 4'b0010.
- R9: A change on `cts` or `dsr` latches delta bits, read at index 6 as follows: bit 0 CTS changed, bit 1 DSR changed, bit 4 `cts`, bit 5 `dsr`. While enabled, the modem cause reports 4'b0000, and the read clears the delta bits.
- R10: Rank from highest to lowest: line errors, receive level, receive timeout, transmit empty, modem change. Index 2 reads {4'b0000, irq_id}.
- R11: `irq` is the OR of the enabled pending causes. With none enabled and pending, `irq` is 0 and `irq_id` is 4'b0001. Both outputs follow a cause change one cycle after the cause state is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a read |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_avail | input | 1 | Receive FIFO holds data |
| rx_lvl_hit | input | 1 | Receive FIFO at or above its level |
| rx_tmo | input | 1 | Receive idle timeout |
| err_ovr | input | 1 | Overrun pulse |
| err_par | input | 1 | Parity error pulse |
| err_frm | input | 1 | Framing error pulse |
| err_brk | input | 1 | Break pulse |
| tx_empty | input | 1 | Transmit FIFO empty |
| cts | input | 1 | Clear-to-send level |
| dsr | input | 1 | Data-set-ready level |
| tx_push | output | 1 | Push `tx_data` into transmit FIFO |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop the receive FIFO |
| divisor | output | 16 | Baud divisor |
| char_len | output | 2 | Character length code |
| stop2 | output | 1 | Longer stop period |
| par_en | output | 1 | Parity enable |
| par_odd | output | 1 | Odd parity select |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Highest pending cause code |

## Verification
A sticky status bit that fails to clear on its read leaves `irq_id` stuck on that cause one cycle after the read. It also hides every lower-ranked cause, which the ranked drain sequence exposes at once. A wrong access-bit decode shows up in two ways: a spurious `tx_push` or `rx_pop` in the cycle after a divisor access, and a divisor byte that does not read back. A wrong rank or enable mask shows as the wrong code, or a false `irq`, two cycles after a cause changes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [2:0] IDX_DATA  = 3'd0;
  localparam logic [2:0] IDX_IEN   = 3'd1;
  localparam logic [2:0] IDX_IID   = 3'd2;
  localparam logic [2:0] IDX_LCTL  = 3'd3;
  localparam logic [2:0] IDX_LSTAT = 3'd5;
  localparam logic [2:0] IDX_MSTAT = 3'd6;

  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;
  localparam int IEN_W     = 4;

  typedef enum logic [3:0] {
    ID_MODEM = 4'b0000,
    ID_NONE  = 4'b0001,
    ID_TXE   = 4'b0010,
    ID_RXLVL = 4'b0100,
    ID_LINE  = 4'b0110,
    ID_RXTO  = 4'b1100
  } irq_id_e;

  typedef struct packed {
    logic line;
    logic rx_lvl;
    logic rx_to;
    logic txe;
    logic modem;
  } irq_src_t;
endpackage

// File: rtl/sio_event_latch.sv
module sio_event_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  // a new event in the same cycle as the clearing read is kept
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= set | (clr ? '0 : q);
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6 / R9: an event always lands in the latch
    assert_event_kept_R6: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    // R6 / R9: a clearing read without a new event empties the bit
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/sio_intr_prio.sv
module sio_intr_prio
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  irq_src_t          pend,
  input  logic [IEN_W-1:0]  ien,
  output logic              irq,
  output logic [3:0]        irq_id
);
  irq_src_t act;
  irq_id_e  id_d;

  always_comb begin
    act.line   = pend.line   & ien[IEN_LINE];
    act.rx_lvl = pend.rx_lvl & ien[IEN_RX];
    act.rx_to  = pend.rx_to  & ien[IEN_RX];
    act.txe    = pend.txe    & ien[IEN_TX];
    act.modem  = pend.modem  & ien[IEN_MODEM];
    if (act.line)        id_d = ID_LINE;
    else if (act.rx_lvl) id_d = ID_RXLVL;
    else if (act.rx_to)  id_d = ID_RXTO;
    else if (act.txe)    id_d = ID_TXE;
    else if (act.modem)  id_d = ID_MODEM;
    else                 id_d = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      irq_id <= ID_NONE;
    end else begin
      irq    <= |act;
      irq_id <= id_d;
    end
  end

  assert_line_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (pend.line && ien[IEN_LINE]) |=> (irq_id == ID_LINE));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> (!irq && irq_id == ID_NONE));
  assert_irq_code_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_id != ID_NONE));
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_avail,
  input  logic              rx_lvl_hit,
  input  logic              rx_tmo,
  input  logic              err_ovr,
  input  logic              err_par,
  input  logic              err_frm,
  input  logic              err_brk,
  input  logic              tx_empty,
  input  logic              cts,
  input  logic              dsr,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_pop,
  output logic [2*DATA_W-1:0] divisor,
  output logic [1:0]        char_len,
  output logic              stop2,
  output logic              par_en,
  output logic              par_odd,
  output logic              irq,
  output logic [3:0]        irq_id
);
  localparam int DIV_W   = 2 * DATA_W;
  localparam int LERR_N  = 4;
  localparam int MDLT_N  = 2;
  localparam int DLAB_B  = 7;
  localparam logic [DATA_W-1:0] LCTL_MASK = DATA_W'(8'h9F);

  logic              acc_rd, acc_wr, dlab;
  logic              wr_thr, wr_div_lo, wr_div_hi, wr_ien, wr_lctl;
  logic              rd_rbr, rd_iid, rd_lstat, rd_mstat;
  logic [DATA_W-1:0] lctl_q, div_lo_q, div_hi_q;
  logic [IEN_W-1:0]  ien_q;
  logic [LERR_N-1:0] lerr_q;
  logic [MDLT_N-1:0] mdlt_set, mdlt_q;
  logic              cts_q, dsr_q, primed_q;
  logic              txe_q, txe_set, txe_clr, tx_empty_q;
  logic [DATA_W-1:0] rd_next;
  irq_src_t          pend;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [2:0] idx);
    return a == ADDR_W'(idx);
  endfunction

  // ---- decode ----
  assign acc_rd    = bus_sel & ~bus_wr;
  assign acc_wr    = bus_sel &  bus_wr;
  assign dlab      = lctl_q[DLAB_B];
  assign wr_thr    = acc_wr & hit(bus_addr, IDX_DATA) & ~dlab;
  assign wr_div_lo = acc_wr & hit(bus_addr, IDX_DATA) &  dlab;
  assign wr_div_hi = acc_wr & hit(bus_addr, IDX_IEN)  &  dlab;
  assign wr_ien    = acc_wr & hit(bus_addr, IDX_IEN)  & ~dlab;
  assign wr_lctl   = acc_wr & hit(bus_addr, IDX_LCTL);
  assign rd_rbr    = acc_rd & hit(bus_addr, IDX_DATA) & ~dlab;
  assign rd_iid    = acc_rd & hit(bus_addr, IDX_IID);
  assign rd_lstat  = acc_rd & hit(bus_addr, IDX_LSTAT);
  assign rd_mstat  = acc_rd & hit(bus_addr, IDX_MSTAT);

  // ---- control registers ----
  always_ff @(posedge clk) begin
    if (rst) begin
      lctl_q   <= '0;
      ien_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (wr_lctl)   lctl_q   <= bus_wdata & LCTL_MASK;
      if (wr_ien)    ien_q    <= bus_wdata[IEN_W-1:0];
      if (wr_div_lo) div_lo_q <= bus_wdata;
      if (wr_div_hi) div_hi_q <= bus_wdata;
    end
  end

  assign divisor  = DIV_W'({div_hi_q, div_lo_q});
  assign char_len = lctl_q[1:0];
  assign stop2    = lctl_q[2];
  assign par_en   = lctl_q[3];
  assign par_odd  = lctl_q[4];

  // ---- FIFO strobes ----
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push <= 1'b0;
      rx_pop  <= 1'b0;
      tx_data <= '0;
    end else begin
      tx_push <= wr_thr;
      rx_pop  <= rd_rbr;
      if (wr_thr) tx_data <= bus_wdata;
    end
  end

  // ---- line error status ----
  sio_event_latch #(.N(LERR_N)) u_lerr (
    .clk (clk),
    .rst (rst),
    .set ({err_brk, err_frm, err_par, err_ovr}),
    .clr (rd_lstat),
    .q   (lerr_q)
  );

  // ---- modem change detect ----
  always_ff @(posedge clk) begin
    if (rst) begin
      cts_q    <= 1'b0;
      dsr_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cts_q    <= cts;
      dsr_q    <= dsr;
      primed_q <= 1'b1;
    end
  end

  assign mdlt_set = primed_q ? {dsr ^ dsr_q, cts ^ cts_q} : '0;

  sio_event_latch #(.N(MDLT_N)) u_mdlt (
    .clk (clk),
    .rst (rst),
    .set (mdlt_set),
    .clr (rd_mstat),
    .q   (mdlt_q)
  );

  // ---- transmit-empty cause ----
  assign txe_set = (tx_empty & ~tx_empty_q)
                 | (wr_ien & bus_wdata[IEN_TX] & ~ien_q[IEN_TX] & tx_empty);
  assign txe_clr = wr_thr | (rd_iid & (irq_id == ID_TXE));

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q      <= 1'b0;
      tx_empty_q <= 1'b1;
    end else begin
      tx_empty_q <= tx_empty;
      if (txe_set)      txe_q <= 1'b1;
      else if (txe_clr) txe_q <= 1'b0;
    end
  end

  // ---- interrupt ranking ----
  always_comb begin
    pend.line   = |lerr_q;
    pend.rx_lvl = rx_lvl_hit;
    pend.rx_to  = rx_tmo;
    pend.txe    = txe_q;
    pend.modem  = |mdlt_q;
  end

  sio_intr_prio u_prio (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .ien    (ien_q),
    .irq    (irq),
    .irq_id (irq_id)
  );

  // ---- read path ----
  always_comb begin
    rd_next = '0;
    unique case (bus_addr)
      ADDR_W'(IDX_DATA):  rd_next = dlab ? div_lo_q : rx_data;
      ADDR_W'(IDX_IEN):   rd_next = dlab ? div_hi_q : DATA_W'(ien_q);
      ADDR_W'(IDX_IID):   rd_next = DATA_W'(irq_id);
      ADDR_W'(IDX_LCTL):  rd_next = lctl_q;
      ADDR_W'(IDX_LSTAT): rd_next = DATA_W'({tx_empty, lerr_q, rx_avail});
      ADDR_W'(IDX_MSTAT): rd_next = DATA_W'({dsr, cts, 2'b00, mdlt_q});
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (acc_rd) rd_data <= rd_next;
  end

  assert_thr_push_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && bus_addr == ADDR_W'(IDX_DATA) && !dlab) |=> tx_push);
  assert_div_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr == ADDR_W'(IDX_DATA) && dlab) |=> (!tx_push && !rx_pop));
  assert_ien_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_wr && bus_addr == ADDR_W'(IDX_IEN) && !dlab) |=> $stable(ien_q));
  assert_txe_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && !txe_set) |=> !txe_q);
endmodule

// File: tb/sio_regbank_tb.sv
`timescale 1ns/1ps
module sio_regbank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_data = 8'hC3;
  logic rx_avail = 0, rx_lvl_hit = 0, rx_tmo = 0;
  logic err_ovr = 0, err_par = 0, err_frm = 0, err_brk = 0;
  logic tx_empty = 1, cts = 0, dsr = 0;
  logic [7:0] rd_data, tx_data;
  logic tx_push, rx_pop, stop2, par_en, par_odd, irq;
  logic [15:0] divisor;
  logic [1:0] char_len;
  logic [3:0] irq_id;

  int n_chk = 0, n_fail = 0;
  logic done = 0;

  always #4 clk = ~clk;

  sio_regbank u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rx_data(rx_data), .rx_avail(rx_avail),
    .rx_lvl_hit(rx_lvl_hit), .rx_tmo(rx_tmo), .err_ovr(err_ovr), .err_par(err_par),
    .err_frm(err_frm), .err_brk(err_brk), .tx_empty(tx_empty), .cts(cts), .dsr(dsr),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .divisor(divisor),
    .char_len(char_len), .stop2(stop2), .par_en(par_en), .par_odd(par_odd),
    .irq(irq), .irq_id(irq_id)
  );

  // {write, index, wdata, expected read}
  localparam logic [19:0] VEC [15] = '{
    {1'b0, 3'd1, 8'h00, 8'h00},  // R1 enables reset to zero
    {1'b0, 3'd3, 8'h00, 8'h00},  // R1 line control reset to zero
    {1'b1, 3'd3, 8'h80, 8'h00},  // R5 set access bit
    {1'b1, 3'd0, 8'h34, 8'h00},  // R3 divisor low
    {1'b1, 3'd1, 8'h12, 8'h00},  // R3 divisor high
    {1'b0, 3'd0, 8'h00, 8'h34},  // R3
    {1'b0, 3'd1, 8'h00, 8'h12},  // R3
    {1'b0, 3'd3, 8'h00, 8'h80},  // R5
    {1'b1, 3'd3, 8'hFF, 8'h00},  // R5 bits 6:5 dropped
    {1'b0, 3'd3, 8'h00, 8'h9F},  // R5
    {1'b1, 3'd3, 8'h1B, 8'h00},  // R5 access bit clear
    {1'b1, 3'd1, 8'hFF, 8'h00},  // R4
    {1'b0, 3'd1, 8'h00, 8'h0F},  // R4 upper bits read zero
    {1'b1, 3'd1, 8'h00, 8'h00},  // R4
    {1'b0, 3'd1, 8'h00, 8'h00}   // R4
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    logic [7:0] r;
    tick(3);
    rst = 0;
    tick(1);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 irq_id", {12'd0, irq_id}, 16'h0001);
    check("R1 divisor", divisor, 16'h0000);
    check("R1 lctl fields", {11'd0, char_len, stop2, par_en, par_odd}, 16'd0);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][18:16], r);
        check($sformatf("R3/R4/R5 vector %0d", i), {8'd0, r}, {8'd0, VEC[i][7:0]});
      end
    end
    check("R3 divisor out", divisor, 16'h1234);
    check("R5 fields", {11'd0, char_len, stop2, par_en, par_odd}, {11'd0, 2'b11, 1'b0, 1'b1, 1'b1});

    // R3: divisor access gives no FIFO strobes
    do_wr(3'd3, 8'h80);
    do_wr(3'd0, 8'h77);
    check("R3 no tx_push", {15'd0, tx_push}, 16'd0);
    check("R3 divisor low update", divisor, 16'h1277);
    do_rd(3'd0, r);
    check("R3 no rx_pop", {15'd0, rx_pop}, 16'd0);
    do_wr(3'd3, 8'h1B);

    // R2: data port
    do_wr(3'd0, 8'h5A);
    check("R2 tx_push", {15'd0, tx_push}, 16'd1);
    check("R2 tx_data", {8'd0, tx_data}, 16'h005A);
    tick(1);
    check("R2 push one cycle", {15'd0, tx_push}, 16'd0);
    do_rd(3'd0, r);
    check("R2 rbr data", {8'd0, r}, 16'h00C3);
    check("R2 rx_pop", {15'd0, rx_pop}, 16'd1);

    // R8: enable with FIFO already empty, ack by id read
    do_wr(3'd1, 8'h02);
    tick(1);
    check("R8 id on enable", {12'd0, irq_id}, 16'h0002);
    check("R8 irq", {15'd0, irq}, 16'd1);
    do_rd(3'd2, r);
    check("R8 id read", {8'd0, r}, 16'h0002);
    tick(1);
    check("R8 cleared by id read", {12'd0, irq_id}, 16'h0001);
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    tick(2);
    check("R8 rising empty", {12'd0, irq_id}, 16'h0002);
    do_wr(3'd0, 8'h11);
    tick(1);
    check("R8 cleared by data write", {12'd0, irq_id}, 16'h0001);

    // R11: disabled cause stays silent but status still latches
    do_wr(3'd1, 8'h00);
    @(negedge clk); err_par = 1;
    @(negedge clk); err_par = 0;
    tick(1);
    check("R11 disabled irq", {15'd0, irq}, 16'd0);
    check("R11 disabled id", {12'd0, irq_id}, 16'h0001);
    do_rd(3'd5, r);
    check("R6 parity latched", {8'd0, r}, 16'h0024);
    do_rd(3'd5, r);
    check("R6 cleared on read", {8'd0, r}, 16'h0020);

    // R6: line cause
    do_wr(3'd1, 8'h04);
    @(negedge clk); err_ovr = 1; err_frm = 1;
    @(negedge clk); err_ovr = 0; err_frm = 0;
    tick(1);
    check("R6 line id", {12'd0, irq_id}, 16'h0006);
    do_rd(3'd5, r);
    check("R6 status bits", {8'd0, r}, 16'h002A);
    tick(1);
    check("R6 id after read", {12'd0, irq_id}, 16'h0001);

    // R7: receive level and timeout
    do_wr(3'd1, 8'h01);
    @(negedge clk); rx_lvl_hit = 1;
    tick(2);
    check("R7 level id", {12'd0, irq_id}, 16'h0004);
    @(negedge clk); rx_lvl_hit = 0; rx_tmo = 1;
    tick(2);
    check("R7 timeout id", {12'd0, irq_id}, 16'h000C);
    @(negedge clk); rx_tmo = 0;
    tick(2);
    check("R7 idle id", {12'd0, irq_id}, 16'h0001);

    // R9: modem change
    do_wr(3'd1, 8'h08);
    @(negedge clk); cts = 1;
    tick(2);
    check("R9 modem id", {12'd0, irq_id}, 16'h0000);
    check("R9 irq", {15'd0, irq}, 16'd1);
    do_rd(3'd6, r);
    check("R9 status", {8'd0, r}, 16'h0011);
    tick(1);
    check("R9 id after read", {12'd0, irq_id}, 16'h0001);
    do_rd(3'd6, r);
    check("R9 delta cleared", {8'd0, r}, 16'h0010);

    // R10: ranked drain
    do_wr(3'd1, 8'h0F);
    @(negedge clk); dsr = 1; rx_lvl_hit = 1; err_par = 1;
    @(negedge clk); err_par = 0;
    tick(1);
    check("R10 line first", {12'd0, irq_id}, 16'h0006);
    do_rd(3'd5, r);
    check("R10 line status", {8'd0, r}, 16'h0024);
    tick(1);
    check("R10 level second", {12'd0, irq_id}, 16'h0004);
    @(negedge clk); rx_lvl_hit = 0;
    tick(2);
    check("R10 tx empty third", {12'd0, irq_id}, 16'h0002);
    do_rd(3'd2, r);
    check("R10 id register", {8'd0, r}, 16'h0002);
    tick(1);
    check("R10 modem last", {12'd0, irq_id}, 16'h0000);
    do_rd(3'd6, r);
    check("R10 modem status", {8'd0, r}, 16'h0032);
    tick(1);
    check("R11 all serviced id", {12'd0, irq_id}, 16'h0001);
    check("R11 all serviced irq", {15'd0, irq}, 16'd0);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule